// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches four asynchronous interrupt pins and turns them into one interrupt request per line. Each line has a two-bit sense mode: it can react to a low level, to any edge, to a falling edge only, or to a rising edge only. The pins first pass through a two-flop synchronizer. Edges are found by comparing the present synchronized sample with the sample from the cycle before.

Edge modes latch a per-line flag. The flag stays set until software writes a one to its bit, or until the line's acknowledge input pulses. Low-level mode latches nothing: the request follows the synchronized pin for as long as the pin stays low. A request reaches the output only when the line's mask bit and the global enable input are both set.

Software reaches the block through a small register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: The sense register (address 0) holds bits [2n+1:2n] as the mode of line n. Encoding: 00 low level, 01 any edge, 10 falling edge, 11 rising edge. All eight bits read back as written.
- R2: After reset, the sense, mask and flag registers read 0 and all requests are low.
- R3: The mask register is at address 1 and the flag register at address 2. Bit n of each belongs to line n, and bits 7:4 of both read as 0.
- R4: A line's request is high only when its mask bit and the global enable input are both 1.
- R5: In low-level mode, the request is high while the synchronized pin is low and drops once it is high. The line's flag never sets in this mode.
- R6: In an edge mode, an edge matching the line's mode sets the line's flag. Mask and global enable do not affect this. A non-matching edge leaves the flag unchanged.
- R7: Writing the flag register clears every flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R8: A one-cycle pulse on a line's acknowledge input clears that line's flag.
- R9: A pin level held across at least one rising clock edge is always captured. An edge flag reads set after the third rising edge that follows the pin change, and not after the second. A low-level request appears after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 sense, 1 mask, 2 flag) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| pin_in | input | 4 | Asynchronous interrupt pins, bit n is line n |
| global_en | input | 1 | Global interrupt enable |
| irq_ack | input | 4 | Per-line acknowledge pulse, clears the edge flag |
| irq_req | output | 4 | Per-line interrupt request |

## Verification
A wrong edge decode or a stuck flag shows in the flag register readback on the third clock after the pin moves. It also shows in irq_req once the mask and global enable are set. A stale previous-sample register would either miss a one-cycle pulse or report a flag one cycle early. The latency check samples the flag both one cycle before and exactly at its expected edge, so either fault is caught. A faulty clear or acknowledge path leaves a flag readable, and that flag keeps its request asserted, on the cycle right after the write or pulse.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_SENSE = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_MASK  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_FLAG  = 2'd2;

  // Does a transition prev->cur match the requested edge mode?
  function automatic logic edge_match(sense_e mode, logic prev, logic cur);
    logic rise, fall;
    rise = !prev && cur;
    fall = prev && !cur;
    case (mode)
      SENSE_ANY:  edge_match = rise || fall;
      SENSE_FALL: edge_match = fall;
      SENSE_RISE: edge_match = rise;
      default:    edge_match = 1'b0;
    endcase
  endfunction

  // Level activity only exists in low-level mode.
  function automatic logic level_match(sense_e mode, logic cur);
    level_match = (mode == SENSE_LOW) && !cur;
  endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= {WIDTH{RST_VAL}};
          else        stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/eis_edge_detect.sv
module eis_edge_detect
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode,
  input  logic   pin_cur,
  output logic   edge_hit,
  output logic   level_act
);

  logic pin_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev_q <= 1'b1;
    else        pin_prev_q <= pin_cur;
  end

  assign edge_hit  = edge_match(mode, pin_prev_q, pin_cur);
  assign level_act = level_match(mode, pin_cur);

  // R5: the level path never fires in an edge mode
  level_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_act |-> (mode == SENSE_LOW && !pin_cur));

  // R6: an edge hit always reflects a real change of the sample
  hit_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |-> (pin_cur != pin_prev_q));

endmodule

// File: rtl/eis_regfile.sv
module eis_regfile
  import ext_irq_pkg::*;
#(
  parameter int unsigned LINES = 4,
  parameter int unsigned DW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [LINES-1:0]  edge_hit,
  input  logic [LINES-1:0]  ack,
  output logic [2*LINES-1:0] sense_q,
  output logic [LINES-1:0]  mask_q,
  output logic [LINES-1:0]  flag_q,
  output logic [DW-1:0]     rdata
);

  localparam int unsigned SW = 2 * LINES;

  logic             sense_we, mask_we, flag_we;
  logic [LINES-1:0] flag_clr;
  logic [LINES-1:0] flag_d;

  assign sense_we = we && (addr == ADDR_SENSE);
  assign mask_we  = we && (addr == ADDR_MASK);
  assign flag_we  = we && (addr == ADDR_FLAG);

  assign flag_clr = (flag_we ? wdata[LINES-1:0] : '0) | ack;
  // a fresh edge wins over a clear in the same cycle
  assign flag_d   = (flag_q & ~flag_clr) | edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
      flag_q  <= '0;
    end else begin
      if (sense_we) sense_q <= wdata[SW-1:0];
      if (mask_we)  mask_q  <= wdata[LINES-1:0];
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_SENSE: rdata[SW-1:0]    = sense_q;
      ADDR_MASK:  rdata[LINES-1:0] = mask_q;
      ADDR_FLAG:  rdata[LINES-1:0] = flag_q;
      default:    rdata = '0;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_chk
      // R5
      low_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_e'(sense_q[2*i +: 2]) == SENSE_LOW && !flag_q[i]) |=> !flag_q[i]);
      // R6
      hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit[i] |=> flag_q[i]);
      // R7
      clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && wdata[i] && !edge_hit[i]) |=> !flag_q[i]);
      // R7
      zero_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !wdata[i] && !ack[i] && flag_q[i]) |=> flag_q[i]);
      // R8
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[i] && !edge_hit[i]) |=> !flag_q[i]);
    end
  endgenerate

endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned LINES = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [LINES-1:0]  pin_in,
  input  logic              global_en,
  input  logic [LINES-1:0]  irq_ack,
  output logic [LINES-1:0]  irq_req
);

  logic [LINES-1:0]   pin_sync;
  logic [LINES-1:0]   edge_hit;
  logic [LINES-1:0]   level_act;
  logic [2*LINES-1:0] sense_q;
  logic [LINES-1:0]   mask_q;
  logic [LINES-1:0]   flag_q;
  logic [LINES-1:0]   line_active;

  eis_sync #(.WIDTH(LINES), .STAGES(SYNC), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (pin_sync)
  );

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      sense_e mode_i;
      assign mode_i = sense_e'(sense_q[2*i +: 2]);

      eis_edge_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_i),
        .pin_cur   (pin_sync[i]),
        .edge_hit  (edge_hit[i]),
        .level_act (level_act[i])
      );

      assign line_active[i] = (mode_i == SENSE_LOW) ? level_act[i] : flag_q[i];
    end
  endgenerate

  eis_regfile #(.LINES(LINES), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .edge_hit (edge_hit),
    .ack      (irq_ack),
    .sense_q  (sense_q),
    .mask_q   (mask_q),
    .flag_q   (flag_q),
    .rdata    (reg_rdata)
  );

  assign irq_req = global_en ? (line_active & mask_q) : '0;

  generate
    for (i = 0; i < LINES; i++) begin : g_req_chk
      // R4
      req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[i] |-> (global_en && mask_q[i]));
    end
  endgenerate

  // R3
  always_comb begin
    if (rst_n && reg_addr != ADDR_SENSE)
      upper_zero_chk: assert (reg_rdata[DW-1:LINES] == '0);
  end

endmodule

// File: tb/test_ext_irq_sense_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_sense_ctrl;

  typedef struct {
    string      rid;
    int         kind;  // 0: irq_req, 1: reg_rdata
    logic [7:0] exp;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [3:0] pin_in = 4'hF;
  logic       global_en = 1'b0;
  logic [3:0] irq_ack = 4'h0;
  logic [3:0] irq_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  sb_item_t sb[$];

  always #2.5 clk = ~clk;

  ext_irq_sense_ctrl i_ext_irq_sense_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .global_en(global_en), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = (it.kind == 0) ? {4'h0, irq_req} : reg_rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.rid, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic expect_reg(string rid, logic [1:0] a, logic [7:0] e);
    sb_item_t it;
    reg_addr = a;
    it.rid = rid; it.kind = 1; it.exp = e;
    sb.push_back(it);
    wait_drain();
  endtask

  task automatic expect_irq(string rid, logic [3:0] e);
    sb_item_t it;
    it.rid = rid; it.kind = 0; it.exp = {4'h0, e};
    sb.push_back(it);
    wait_drain();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    tick(1);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic set_pins(logic [3:0] p);
    tick(1);
    pin_in = p;
  endtask

  initial begin
    #1_000_000;  // 200000 cycles at 5 ns
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R2 reset state
    expect_reg("R2 sense", 2'd0, 8'h00);
    expect_reg("R2 mask", 2'd1, 8'h00);
    expect_reg("R2 flag", 2'd2, 8'h00);
    expect_irq("R2 irq", 4'h0);

    // R1: line3 rise, line2 fall, line1 any, line0 low
    wr(2'd0, 8'hE4);
    expect_reg("R1 sense readback", 2'd0, 8'hE4);
    wr(2'd1, 8'hFF);
    expect_reg("R3 mask upper zero", 2'd1, 8'h0F);
    tick(1);
    global_en = 1'b1;

    // R5 low level on line0
    pin_in = 4'hE;
    tick(2);
    expect_irq("R5 low asserts", 4'h1);
    expect_reg("R5 no flag in low mode", 2'd2, 8'h00);
    set_pins(4'hF);
    tick(2);
    expect_irq("R5 high drops", 4'h0);

    // R9 latency and R6 falling edge on line2
    set_pins(4'hB);
    tick(2);
    expect_reg("R9 flag not yet", 2'd2, 8'h00);
    tick(1);
    expect_reg("R6 falling sets flag", 2'd2, 8'h04);
    expect_irq("R6 falling request", 4'h4);

    // R7 write zero / write one
    wr(2'd2, 8'h00);
    expect_reg("R7 zero write keeps", 2'd2, 8'h04);
    wr(2'd2, 8'h04);
    expect_reg("R7 one write clears", 2'd2, 8'h00);
    expect_irq("R7 request gone", 4'h0);

    // R6 rising edge on a falling-mode line is ignored
    set_pins(4'hF);
    tick(3);
    expect_reg("R6 wrong edge ignored", 2'd2, 8'h00);

    // R6 rising mode on line3
    set_pins(4'h7);
    tick(3);
    expect_reg("R6 fall ignored in rise mode", 2'd2, 8'h00);
    set_pins(4'hF);
    tick(3);
    expect_reg("R6 rising sets flag", 2'd2, 8'h08);

    // R8 acknowledge
    tick(1);
    irq_ack = 4'h8;
    tick(1);
    irq_ack = 4'h0;
    expect_reg("R8 ack clears flag", 2'd2, 8'h00);
    expect_irq("R8 request gone", 4'h0);

    // R9 one-cycle pulse on line1 (any edge), masked (R6)
    wr(2'd1, 8'h00);
    set_pins(4'hD);
    tick(1);
    pin_in = 4'hF;
    tick(4);
    expect_reg("R9 short pulse captured", 2'd2, 8'h02);
    expect_irq("R4 masked line silent", 4'h0);
    wr(2'd1, 8'h02);
    expect_irq("R4 unmasked request", 4'h2);
    global_en = 1'b0;
    expect_irq("R4 global disable", 4'h0);
    tick(1);
    global_en = 1'b1;
    pin_in = 4'hE;
    tick(2);
    expect_irq("R4 masked low level", 4'h2);
    set_pins(4'hF);
    tick(2);

    wr(2'd2, 8'h0F);
    expect_reg("R7 clear all", 2'd2, 8'h00);
    wr(2'd0, 8'h1B);
    expect_reg("R1 second pattern", 2'd0, 8'h1B);
    expect_reg("R3 unused address", 2'd3, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule